// File: doc/BRIEF.md
# Addressed Serial Trim-Code Register Bank

This block is the digital control core of a multi-channel trim converter. A host sends short frames over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame carries a channel address followed by an 8-bit code. When the select line is released, the block decodes the address and stores the code in one of twelve holding registers. Each register drives one channel's code output.

All three serial wires are brought into a faster system clock through two-flop synchronizers. Data is sampled on the detected rising edge of the serial clock. An asynchronous preset returns every channel to the midscale code. A shutdown input removes the drive enable of every channel but keeps the stored codes. Writes are still accepted during shutdown, and the codes they store are seen at the outputs once the drive returns.

The serial link paces itself, so there is no valid/ready handshake. The host never sees back-pressure, and a frame is applied as soon as it closes. The preset, shutdown and reset pins are plain level controls. The serial clock must stay below a sixth of the system clock rate, and each serial level must be held for at least three system cycles.

Top module: `trim_bank_ctrl`

## Requirements
- R1: A frame is 12 bits. The first 4 bits form the address, most significant bit first. The last 8 bits form the code, most significant bit first. Address a writes the code to channel a+1, which appears on `chan_code[a*8 +: 8]`.
- R2: Bits are captured only on rising serial-clock edges that occur while `ser_cs_n` is low. Edges that occur while it is high have no effect.
- R3: When more than 12 bits are clocked in before the select rises, only the last 12 bits form the frame.
- R4: The write happens on the rising edge of `ser_cs_n`. The new code is visible within 8 system cycles of that edge, and no other channel changes.
- R5: Addresses 12 to 15 select no channel. All codes stay unchanged.
- R6: A frame with fewer than 12 bits captured since the select fell causes no write.
- R7: While `preset_n` is low, every code reads 0x80 at once, without waiting for a clock edge. The codes stay 0x80 after `preset_n` is released.
- R8: One system cycle after `shdn` goes high, all bits of `chan_drive_en` are 0 and the codes are preserved. One cycle after `shdn` goes low, all bits are 1 again.
- R9: Frames received while `shdn` is high still update the codes. Those codes are the ones present when drive is restored.
- R10: While `rst_n` is low, every code is 0x80 and `chan_drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preset_n | input | 1 | Active-low asynchronous midscale preset |
| shdn | input | 1 | Shutdown; high removes channel drive |
| ser_clk | input | 1 | Serial clock, sampled on rising edges |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_dat | input | 1 | Serial data |
| chan_code | output | 96 | Twelve 8-bit codes; channel n+1 in bits [n*8+7:n*8] |
| chan_drive_en | output | 12 | Per-channel drive enable |

## Verification
The address space is swept exhaustively. All sixteen addresses are sent with several codes each. This shows the +1 mapping is correct, and that the four unused addresses leave every channel untouched. Walking-one codes on a single channel show whether bit order or bit position is wrong. Overlong frames, short frames, and clock edges made with the select high show whether the frame boundary is counted from the select edges rather than from the total number of clock edges. Preset pulses, and writes made inside a shutdown window, show that the code storage is separate from the drive gating.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int unsigned CH_COUNT   = 12;
  localparam int unsigned ADDR_BITS  = 4;
  localparam int unsigned CODE_BITS  = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic logic [CODE_BITS-1:0] mid_code();
    logic [CODE_BITS-1:0] m;
    m = '0;
    m[CODE_BITS-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/trim_frame_rx.sv
module trim_frame_rx #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_clk,
  input  logic          s_cs_n,
  input  logic          s_dat,
  output logic          frm_vld,
  output logic [AW-1:0] frm_addr,
  output logic [DW-1:0] frm_data
);
  localparam int unsigned FW = AW + DW;
  localparam int unsigned CW = $clog2(FW + 1);

  logic          clk_q;
  logic          csn_q;
  logic [FW-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic          clk_rise;
  logic          cs_open;
  logic          cs_close;

  assign clk_rise = s_clk & ~clk_q;
  assign cs_open  = csn_q & ~s_cs_n;
  assign cs_close = ~csn_q & s_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= 1'b0;
      csn_q    <= 1'b1;
      shreg    <= '0;
      bit_cnt  <= '0;
      frm_vld  <= 1'b0;
      frm_addr <= '0;
      frm_data <= '0;
    end else begin
      clk_q   <= s_clk;
      csn_q   <= s_cs_n;
      frm_vld <= 1'b0;
      if (cs_open) begin
        bit_cnt <= '0;
      end else if (!s_cs_n && clk_rise) begin
        shreg <= {shreg[FW-2:0], s_dat};
        if (bit_cnt != CW'(FW)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_close && bit_cnt == CW'(FW)) begin
        frm_vld  <= 1'b1;
        frm_addr <= shreg[FW-1 -: AW];
        frm_data <= shreg[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/trim_chan_regs.sv
module trim_chan_regs #(
  parameter int unsigned NCH = 12,
  parameter int unsigned AW  = 4,
  parameter int unsigned DW  = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] codes
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] hold;
    logic          hit;

    assign hit = wr_en && (wr_addr == AW'(ch));

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)   hold <= MID;
      else if (hit) hold <= wr_data;
    end

    assign codes[ch*DW +: DW] = hold;
  end
endmodule

// File: rtl/trim_drive_ctl.sv
module trim_drive_ctl #(
  parameter int unsigned NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shdn,
  output logic [NCH-1:0] drive_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_en <= '0;
    else        drive_en <= {NCH{~shdn}};
  end
endmodule

// File: rtl/trim_bank_ctrl.sv
module trim_bank_ctrl
  import trim_pkg::*;
#(
  parameter int unsigned NCH   = CH_COUNT,
  parameter int unsigned AW    = ADDR_BITS,
  parameter int unsigned DW    = CODE_BITS,
  parameter int unsigned SYNCN = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_n,
  input  logic              shdn,
  input  logic              ser_clk,
  input  logic              ser_cs_n,
  input  logic              ser_dat,
  output logic [NCH*DW-1:0] chan_code,
  output logic [NCH-1:0]    chan_drive_en
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic [2:0]    ser_sync;
  logic          clr_n;
  logic          frm_vld;
  logic [AW-1:0] frm_addr;
  logic [DW-1:0] frm_data;

  trim_sync #(.WIDTH(3), .STAGES(SYNCN), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_clk, ser_cs_n, ser_dat}),
    .q     (ser_sync)
  );

  trim_frame_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_clk    (ser_sync[2]),
    .s_cs_n   (ser_sync[1]),
    .s_dat    (ser_sync[0]),
    .frm_vld  (frm_vld),
    .frm_addr (frm_addr),
    .frm_data (frm_data)
  );

  assign clr_n = rst_n & preset_n;

  trim_chan_regs #(.NCH(NCH), .AW(AW), .DW(DW), .MID(MID)) u_regs (
    .clk     (clk),
    .clr_n   (clr_n),
    .wr_en   (frm_vld),
    .wr_addr (frm_addr),
    .wr_data (frm_data),
    .codes   (chan_code)
  );

  trim_drive_ctl #(.NCH(NCH)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn     (shdn),
    .drive_en (chan_drive_en)
  );
endmodule

// File: rtl/trim_bank_chk.sv
module trim_bank_chk #(
  parameter int unsigned NCH = 12,
  parameter int unsigned AW  = 4,
  parameter int unsigned DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              preset_n,
  input logic              shdn,
  input logic              ser_cs_n,
  input logic [NCH*DW-1:0] chan_code,
  input logic [NCH-1:0]    chan_drive_en,
  input logic              frm_vld,
  input logic [AW-1:0]     frm_addr,
  input logic [DW-1:0]     frm_data
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  // R8
  shdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> chan_drive_en == '0);

  // R8
  drive_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn |=> chan_drive_en == {NCH{1'b1}});

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    (frm_vld && frm_addr < AW'(NCH)) |=>
      chan_code[$past(frm_addr)*DW +: DW] == $past(frm_data));

  // R5
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    (frm_vld && frm_addr >= AW'(NCH)) |=> $stable(chan_code));

  // R4
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    !frm_vld |=> $stable(chan_code));

  // R4
  close_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |-> ser_cs_n);

  // R7
  preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> chan_code == {NCH{MID}});
endmodule

bind trim_bank_ctrl trim_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .preset_n      (preset_n),
  .shdn          (shdn),
  .ser_cs_n      (ser_cs_n),
  .chan_code     (chan_code),
  .chan_drive_en (chan_drive_en),
  .frm_vld       (frm_vld),
  .frm_addr      (frm_addr),
  .frm_data      (frm_data)
);

// File: tb/trim_bank_ctrl_tb.sv
`timescale 1ns/1ps
module trim_bank_ctrl_tb;
  localparam int NCH = 12;
  localparam int DW  = 8;
  localparam int VW  = NCH*DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preset_n = 1'b1;
  logic shdn = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_cs_n = 1'b1;
  logic ser_dat = 1'b0;
  logic [VW-1:0]  chan_code;
  logic [NCH-1:0] chan_drive_en;

  logic [VW-1:0] exp_codes;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  trim_bank_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .preset_n      (preset_n),
    .shdn          (shdn),
    .ser_clk       (ser_clk),
    .ser_cs_n      (ser_cs_n),
    .ser_dat       (ser_dat),
    .chan_code     (chan_code),
    .chan_drive_en (chan_drive_en)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    ser_dat = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    wait_cyc(6);
    ser_clk = 1'b0;
    wait_cyc(3);
  endtask

  // shifts the low n bits of v, most significant first, inside one select window
  task automatic send_bits(input logic [31:0] v, input int n);
    ser_cs_n = 1'b0;
    wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) clock_bit(v[i]);
    ser_cs_n = 1'b1;
    wait_cyc(10);
  endtask

  task automatic write_frame(input int a, input logic [7:0] d);
    send_bits({20'd0, 4'(a), d}, 12);
    if (a < NCH) exp_codes[a*DW +: DW] = d;
  endtask

  initial begin
    wait_cyc(150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    exp_codes = {NCH{8'h80}};
    wait_cyc(4);
    // R10 reset state
    check("R10 codes in reset", chan_code, {NCH{8'h80}});
    check("R10 drive in reset", VW'(chan_drive_en), '0);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R8 drive after reset", VW'(chan_drive_en), VW'({NCH{1'b1}}));

    // R1 R5 exhaustive address sweep with several codes
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 16; a++) begin
        write_frame(a, 8'((a * 37 + p * 91 + 5) & 8'hff));
        check(a < NCH ? "R1 addressed write" : "R5 unused address", chan_code, exp_codes);
      end
    end

    // R1 bit order: walking one on channel 7 (address 6)
    for (int b = 0; b < 8; b++) begin
      write_frame(6, 8'(1 << b));
      check("R1 walking one", chan_code, exp_codes);
    end

    // R4 out-of-order single writes touch one channel only
    write_frame(11, 8'hC3);
    check("R4 last channel", chan_code, exp_codes);
    write_frame(0, 8'h3C);
    check("R4 first channel", chan_code, exp_codes);

    // R3 overlong frame: 4 junk bits then address 2, code 0x5A
    send_bits({16'd0, 4'hF, 4'd2, 8'h5A}, 16);
    exp_codes[2*DW +: DW] = 8'h5A;
    check("R3 last twelve bits kept", chan_code, exp_codes);

    // R6 short frame of 11 bits
    send_bits({21'd0, 11'h7FF}, 11);
    check("R6 short frame ignored", chan_code, exp_codes);

    // R2 four edges while select high, then only 8 bits with select low
    for (int i = 0; i < 4; i++) clock_bit(1'b1);
    wait_cyc(6);
    send_bits({24'd0, 8'hE7}, 8);
    check("R2 edges with select high ignored", chan_code, exp_codes);

    // R7 asynchronous preset
    @(negedge clk);
    #1 preset_n = 1'b0;
    #1 check("R7 preset immediate", chan_code, {NCH{8'h80}});
    wait_cyc(3);
    preset_n = 1'b1;
    exp_codes = {NCH{8'h80}};
    wait_cyc(2);
    check("R7 preset held after release", chan_code, exp_codes);

    // R8 R9 shutdown
    write_frame(4, 8'h21);
    shdn = 1'b1;
    wait_cyc(1);
    check("R8 drive removed", VW'(chan_drive_en), '0);
    check("R8 codes preserved", chan_code, exp_codes);
    write_frame(9, 8'hA5);
    check("R9 write during shutdown", chan_code, exp_codes);
    check("R8 drive still off", VW'(chan_drive_en), '0);
    shdn = 1'b0;
    wait_cyc(1);
    check("R8 drive restored", VW'(chan_drive_en), VW'({NCH{1'b1}}));
    check("R9 codes after release", chan_code, exp_codes);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule